// File: doc/BRIEF.md
# Paired Palette Entry Decoder

This block is the colour palette front end of a display controller. Software writes it over a simple register bus. Each 32-bit bus word carries two 16-bit colour entries. The block keeps every raw word so that software can read it back. On each write it also expands both entries into 24-bit RGB and stores them in a 256-entry colour table.

A pixel pipeline presents an 8-bit colour index on the lookup port. The 24-bit colour appears on the next clock. A lookup that meets a write to the same entry in the same cycle returns the freshly written colour. The intensity bit carried in each entry does not affect the expanded colour.

Top module: `pal_pair_decoder`

## Requirements
- R1: A bus access hits the palette only when the byte address is 0x200 to 0x3FF, that is when bus_addr[11:9] == 3'b001. The word index is bus_addr[8:2] and bus_addr[1:0] is ignored. A write outside the window changes no raw word and no colour entry.
- R2: A read request (bus_req=1, bus_we=0) inside the window loads bus_rdata at the next clock edge with the raw word last written to that index. A read outside the window loads zero. bus_rdata holds its value in cycles without a read request.
- R3: Raw word n carries colour entry 2n in bits [15:0] and colour entry 2n+1 in bits [31:16].
- R4: Within an entry, bits [4:0] are red, [9:5] green and [14:10] blue. Each 5-bit component is shifted left by 3 with zero fill. The colour is presented as lk_rgb = {red[23:16], green[15:8], blue[7:0]}.
- R5: Bit 15 of an entry (intensity) has no effect on the expanded colour.
- R6: lk_rgb is registered. It shows the colour for the lk_idx sampled at the previous clock edge and does not change between edges.
- R7: Both colour entries of a written word are updated at the clock edge that accepts the write. A lookup of either entry presented in the next cycle returns the new colour.
- R8: When a lookup and an accepted write to the same entry share a cycle, lk_rgb returns the colour being written.
- R9: Reset (rst_n low, asynchronous) clears every raw word, every colour entry, bus_rdata and lk_rgb to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data: two packed colour entries |
| bus_rdata | output | 32 | Registered read data |
| lk_idx | input | 8 | Colour index to look up |
| lk_rgb | output | 24 | Registered 24-bit colour for the index |

## Verification
The hardest situation to reach from the ports is a lookup and a write landing on the same entry in the same cycle. Both lanes of the pair have to be covered: the low-half entry and the high-half entry. Directed cases drive the write and the matching index together for each lane. The random phase also issues each write together with a lookup whose index is steered to the written word on part of the iterations. Writes just outside both ends of the window, including one whose word index aliases word 0, are checked by reading back and looking up the entries they could have corrupted.

// File: rtl/pal_pkg.sv
package pal_pkg;
   localparam int PAL_CH_W = 8;

   typedef struct packed {
      logic [PAL_CH_W-1:0] red;
      logic [PAL_CH_W-1:0] green;
      logic [PAL_CH_W-1:0] blue;
   } rgb_t;
endpackage

// File: rtl/pal_addr_decode.sv
module pal_addr_decode #(
   parameter int ADDR_W   = 12,
   parameter int WORD_AW  = 7,
   parameter int BYTE_SH  = 2,
   parameter int WIN_BASE = 'h200
) (
   input  logic               req,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   output logic               in_win,
   output logic               wr_hit,
   output logic               rd_req,
   output logic [WORD_AW-1:0] word_idx
);
   localparam int TAG_LSB = WORD_AW + BYTE_SH;
   localparam int TAG_W   = ADDR_W - TAG_LSB;
   localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(WIN_BASE);
   localparam logic [TAG_W-1:0]  WIN_TAG  = BASE_VEC[ADDR_W-1:TAG_LSB];

   logic unused_byte_bits;
   assign unused_byte_bits = &{1'b0, addr[BYTE_SH-1:0]};

   assign in_win   = (addr[ADDR_W-1:TAG_LSB] == WIN_TAG);
   assign word_idx = addr[TAG_LSB-1:BYTE_SH];
   assign wr_hit   = req & we & in_win;
   assign rd_req   = req & ~we;
endmodule

// File: rtl/pal_entry_expand.sv
module pal_entry_expand
   import pal_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int ENTRY_W = 16,
   parameter int COMP_W  = 5,
   parameter int LANES   = 2
) (
   input  logic [BUS_W-1:0]       word,
   output rgb_t [LANES-1:0]       rgb
);
   localparam int SHIFT = PAL_CH_W - COMP_W;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam int BASE = ln * ENTRY_W;
      logic [COMP_W-1:0] c_r, c_g, c_b;
      logic unused_upper;
      assign c_r = word[BASE            +: COMP_W];
      assign c_g = word[BASE + COMP_W   +: COMP_W];
      assign c_b = word[BASE + 2*COMP_W +: COMP_W];
      // bits above the three components (intensity) do not reach the colour
      assign unused_upper = &{1'b0, word[BASE + 3*COMP_W +: ENTRY_W - 3*COMP_W]};
      if (SHIFT > 0) begin : g_pad
         assign rgb[ln].red   = {c_r, {SHIFT{1'b0}}};
         assign rgb[ln].green = {c_g, {SHIFT{1'b0}}};
         assign rgb[ln].blue  = {c_b, {SHIFT{1'b0}}};
      end else begin : g_nopad
         assign rgb[ln].red   = c_r;
         assign rgb[ln].green = c_g;
         assign rgb[ln].blue  = c_b;
      end
   end
endmodule

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
   parameter int BUS_W     = 32,
   parameter int RAW_DEPTH = 128,
   parameter int WORD_AW   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic               rd_in_win,
   input  logic [WORD_AW-1:0] idx,
   input  logic [BUS_W-1:0]   wdata,
   output logic [BUS_W-1:0]   rdata
);
   logic [BUS_W-1:0] raw_q [RAW_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < RAW_DEPTH; w++) raw_q[w] <= '0;
      end else if (wr_en) begin
         raw_q[idx] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_in_win ? raw_q[idx] : '0;
   end
endmodule

// File: rtl/pal_color_table.sv
module pal_color_table
   import pal_pkg::*;
#(
   parameter int WORD_AW = 7,
   parameter int LANES   = 2,
   parameter int IDX_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WORD_AW-1:0] wr_word,
   input  rgb_t [LANES-1:0]   wr_rgb,
   input  logic [IDX_W-1:0]   lk_idx,
   output rgb_t               lk_rgb
);
   localparam int LANE_W  = $clog2(LANES);
   localparam int ENTRIES = 1 << IDX_W;

   rgb_t tbl_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) tbl_q[e] <= '0;
      end else if (wr_en) begin
         for (int ln = 0; ln < LANES; ln++)
            tbl_q[{wr_word, LANE_W'(ln)}] <= wr_rgb[ln];
      end
   end

   logic lk_hit;
   assign lk_hit = wr_en & (wr_word == lk_idx[IDX_W-1:LANE_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lk_rgb <= '0;
      else if (lk_hit) lk_rgb <= wr_rgb[lk_idx[LANE_W-1:0]];
      else             lk_rgb <= tbl_q[lk_idx];
   end
endmodule

// File: rtl/pal_pair_decoder.sv
module pal_pair_decoder
   import pal_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int BUS_W     = 32,
   parameter int ENTRY_W   = 16,
   parameter int COMP_W    = 5,
   parameter int RAW_DEPTH = 128,
   parameter int IDX_W     = 8,
   parameter int WIN_BASE  = 'h200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic [IDX_W-1:0]   lk_idx,
   output logic [3*PAL_CH_W-1:0] lk_rgb
);
   localparam int LANES     = BUS_W / ENTRY_W;
   localparam int WORD_AW   = $clog2(RAW_DEPTH);
   localparam int BYTE_SH   = $clog2(BUS_W / 8);
   localparam int WIN_BYTES = RAW_DEPTH * (BUS_W / 8);

   if (LANES * ENTRY_W != BUS_W) begin : g_bad_pack
      $error("bus width must hold a whole number of entries");
   end
   if (LANES < 2 || (1 << $clog2(LANES)) != LANES) begin : g_bad_lanes
      $error("entries per word must be a power of two of at least 2");
   end
   if (3 * COMP_W >= ENTRY_W + 1 || COMP_W > PAL_CH_W) begin : g_bad_comp
      $error("component width does not fit the entry or channel");
   end
   if (RAW_DEPTH * LANES != (1 << IDX_W) || (1 << WORD_AW) != RAW_DEPTH) begin : g_bad_depth
      $error("raw depth and index width disagree");
   end
   if (WIN_BASE % WIN_BYTES != 0 || WIN_BASE + WIN_BYTES > (1 << ADDR_W)) begin : g_bad_base
      $error("window base must be aligned to the window size");
   end

   logic               in_win, wr_hit, rd_req;
   logic [WORD_AW-1:0] word_idx;
   rgb_t [LANES-1:0]   wr_rgb;
   rgb_t               lk_q;

   pal_addr_decode #(
      .ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .BYTE_SH(BYTE_SH), .WIN_BASE(WIN_BASE)
   ) u_dec (
      .req(bus_req), .we(bus_we), .addr(bus_addr),
      .in_win(in_win), .wr_hit(wr_hit), .rd_req(rd_req), .word_idx(word_idx)
   );

   pal_entry_expand #(
      .BUS_W(BUS_W), .ENTRY_W(ENTRY_W), .COMP_W(COMP_W), .LANES(LANES)
   ) u_exp (
      .word(bus_wdata), .rgb(wr_rgb)
   );

   pal_raw_store #(
      .BUS_W(BUS_W), .RAW_DEPTH(RAW_DEPTH), .WORD_AW(WORD_AW)
   ) u_raw (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .rd_en(rd_req),
      .rd_in_win(in_win), .idx(word_idx), .wdata(bus_wdata), .rdata(bus_rdata)
   );

   pal_color_table #(
      .WORD_AW(WORD_AW), .LANES(LANES), .IDX_W(IDX_W)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wr_word(word_idx),
      .wr_rgb(wr_rgb), .lk_idx(lk_idx), .lk_rgb(lk_q)
   );

   assign lk_rgb = lk_q;
endmodule

// File: rtl/pal_pair_decoder_chk.sv
module pal_pair_decoder_chk #(
   parameter int ADDR_W    = 12,
   parameter int BUS_W     = 32,
   parameter int ENTRY_W   = 16,
   parameter int COMP_W    = 5,
   parameter int RAW_DEPTH = 128,
   parameter int IDX_W     = 8,
   parameter int WIN_BASE  = 'h200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [IDX_W-1:0]  lk_idx,
   input logic [23:0]       lk_rgb
);
   localparam int WIN_BYTES = RAW_DEPTH * (BUS_W / 8);
   localparam int BYTE_SH   = $clog2(BUS_W / 8);
   localparam int LANE_W    = $clog2(BUS_W / ENTRY_W);
   localparam int SHIFT     = 8 - COMP_W;

   logic chk_in_win, chk_wr, chk_same_word;
   logic [ENTRY_W-1:0] chk_entry;
   logic [23:0] chk_colour;

   assign chk_in_win = (32'(bus_addr) >= WIN_BASE) && (32'(bus_addr) < WIN_BASE + WIN_BYTES);
   assign chk_wr     = bus_req && bus_we && chk_in_win;
   assign chk_same_word = (32'(bus_addr - ADDR_W'(WIN_BASE)) >> BYTE_SH) == (32'(lk_idx) >> LANE_W);
   assign chk_entry  = ENTRY_W'(bus_wdata >> (ENTRY_W * 32'(lk_idx[LANE_W-1:0])));
   assign chk_colour = {8'(chk_entry[COMP_W-1:0])        << SHIFT,
                        8'(chk_entry[2*COMP_W-1:COMP_W]) << SHIFT,
                        8'(chk_entry[3*COMP_W-1:2*COMP_W]) << SHIFT};

   // R2: a read outside the window returns zero
   p_outside_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && !chk_in_win) |=> (bus_rdata == '0));

   // R2: read data holds without a read request
   p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> $stable(bus_rdata));

   // R4: expanded components carry zero low bits
   p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_rgb[SHIFT-1:0] == '0) && (lk_rgb[8 +: SHIFT] == '0) && (lk_rgb[16 +: SHIFT] == '0));

   // R8: same-cycle write and lookup of one entry returns the new colour
   p_bypass_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_wr && chk_same_word) |=> (lk_rgb == $past(chk_colour)));

   // R6: steady index with no writes keeps the output steady
   p_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_wr && $past(!chk_wr) && $stable(lk_idx)) |=> $stable(lk_rgb));
endmodule

bind pal_pair_decoder pal_pair_decoder_chk #(
   .ADDR_W(ADDR_W), .BUS_W(BUS_W), .ENTRY_W(ENTRY_W), .COMP_W(COMP_W),
   .RAW_DEPTH(RAW_DEPTH), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)
) u_chk (.*);

// File: tb/tb_pal_pair_decoder.sv
`timescale 1ns/1ps
module tb_pal_pair_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  lk_idx = '0;
   logic [23:0] lk_rgb;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [31:0] raw_m [128];

   always #4 clk = ~clk;

   pal_pair_decoder dut (.*);

   function automatic logic [23:0] exp_col(logic [15:0] e);
      return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
   endfunction

   function automatic logic [23:0] model_lk(logic [7:0] idx);
      logic [31:0] w = raw_m[idx[7:1]];
      return exp_col(idx[0] ? w[31:16] : w[15:0]);
   endfunction

   function automatic bit in_win(logic [11:0] a);
      return a[11:9] == 3'b001;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(logic [11:0] a, logic [31:0] d);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 0; bus_we = 0;
      if (in_win(a)) raw_m[a[8:2]] = d;
   endtask

   task automatic do_read(logic [11:0] a, string tag);
      bus_req = 1; bus_we = 0; bus_addr = a;
      @(negedge clk);
      bus_req = 0;
      chk(tag, bus_rdata, in_win(a) ? raw_m[a[8:2]] : 32'h0);
   endtask

   task automatic do_look(logic [7:0] idx, string tag);
      lk_idx = idx;
      @(negedge clk);
      chk(tag, 32'(lk_rgb), 32'(model_lk(idx)));
   endtask

   // write and lookup in the same cycle
   task automatic write_look(logic [11:0] a, logic [31:0] d, logic [7:0] idx, string tag);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; lk_idx = idx;
      @(negedge clk);
      bus_req = 0; bus_we = 0;
      if (in_win(a)) raw_m[a[8:2]] = d;
      chk(tag, 32'(lk_rgb), 32'(model_lk(idx)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 128; i++) raw_m[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 lk_rgb after reset", 32'(lk_rgb), 32'h0);
      chk("R9 rdata after reset", bus_rdata, 32'h0);
      do_read(12'h2A0, "R9 raw word after reset");
      do_look(8'h55, "R9 colour after reset");

      // R4 / R5 / R3 directed
      do_write(12'h200, 32'h8000_FFFF);
      do_look(8'd0, "R4 full white entry 0");
      chk("R4 white value", 32'(lk_rgb), 32'h00F8F8F8);
      do_look(8'd1, "R5 intensity-only entry 1");
      chk("R5 intensity ignored", 32'(lk_rgb), 32'h0);
      do_write(12'h204, 32'h7C00_001F);
      do_look(8'd2, "R3 low half -> entry 2 red");
      chk("R4 red position", 32'(lk_rgb), 32'h00F80000);
      do_look(8'd3, "R3 high half -> entry 3 blue");
      chk("R4 blue position", 32'(lk_rgb), 32'h000000F8);
      do_write(12'h3FF, 32'h03E0_83E0);
      do_read(12'h3FC, "R1 R2 top word readback");
      do_look(8'd254, "R5 green with intensity");
      chk("R5 green value", 32'(lk_rgb), 32'h0000F800);
      do_look(8'd255, "R1 top entry");

      // R1 writes outside the window are ignored
      do_write(12'h400, 32'hFFFF_FFFF);
      do_write(12'h1FC, 32'h1234_5678);
      do_write(12'h000, 32'hDEAD_BEEF);
      do_read(12'h200, "R1 word 0 untouched");
      do_look(8'd1, "R1 entry 1 untouched");
      do_look(8'd254, "R1 entry 254 untouched");
      do_read(12'h400, "R2 outside read zero");
      do_read(12'h1FC, "R2 below window read zero");

      // R7 both entries visible right after the write
      do_write(12'h228, 32'h2108_4210);
      do_look(8'd20, "R7 low entry next cycle");
      do_look(8'd21, "R7 high entry next cycle");

      // R8 same-cycle bypass on both lanes
      write_look(12'h230, 32'h7FFF_0421, 8'd24, "R8 bypass low lane");
      write_look(12'h230, 32'h0C63_8000, 8'd25, "R8 bypass high lane");

      // R6 output registered: no change before the edge
      lk_idx = 8'd2;
      @(negedge clk);
      lk_idx = 8'd3;
      #1;
      chk("R6 held before edge", 32'(lk_rgb), 32'(model_lk(8'd2)));
      @(negedge clk);
      chk("R6 updated after edge", 32'(lk_rgb), 32'(model_lk(8'd3)));

      // random phase
      for (int it = 0; it < 600; it++) begin
         int unsigned sel = $urandom_range(0, 9);
         logic [11:0] a;
         if (sel < 8) a = 12'h200 | 12'($urandom_range(0, 511));
         else begin
            a = 12'($urandom);
            if (in_win(a)) a[11] = 1'b1;
         end
         case ($urandom_range(0, 3))
            0: do_write(a, $urandom);
            1: do_read(a, "R2 random read");
            2: do_look(8'($urandom), "R4 random lookup");
            default: begin
               logic [7:0] ix = ($urandom_range(0, 1) == 0) ? {a[8:2], 1'($urandom)} : 8'($urandom);
               write_look(a, $urandom, ix, "R8 random write with lookup");
            end
         endcase
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule